// File: doc/BRIEF.md
# Cascadable Product-Term Sum Array

This block is an array of logic slices, each forming a programmable sum-of-products function. Every slice owns five product terms. A term is the AND of chosen literals. A literal is a signal or its complement, taken from a global input bus and from a regional bus of inverted terms that the slices of one region share. A slice ORs its enabled terms together with a cascade input from the slice below it. It then passes the sum through an XOR stage. That stage either fixes the output polarity or folds in a fifth term.

Sums can ripple through a run of neighbouring slices, so one output can cover up to five terms per slice across a whole chain. By default a chain is eight slices long, which gives forty terms. Each slice also drives one foldback line, the inverse of a chosen term, onto its region's bus. Software loads the array one slice at a time. Each write places a full configuration word into one slice. The outputs are purely combinational in the global inputs and the stored configuration.

Top module: `pterm_array`

## Requirements
- R1: After reset every configuration bit is zero, so every slice drives `sum_out` 0 and `fold_out` 0 for any value of `glb`.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_data` replaces the configuration of slice `cfg_addr`, and the outputs reflect it from that edge on. A write to an address of `N_SLICE` or more changes nothing. Outputs change only on such a write or on a change of `glb`.
- R3: Term t of a slice uses configuration bits from t*TW upward, where TW = 1 + 2*(N_GLB+REGION). Bit t*TW+1+2k selects source k true and bit t*TW+2+2k selects it complemented. Sources 0..N_GLB-1 are `glb`, and the rest are the regional foldback lines. A term with no literal selected is 1. A term that selects both polarities of one source is 0.
- R4: Bit t*TW enables term t into the slice's OR. A term whose enable bit is 0 adds nothing to the sum, whatever its value.
- R5: A slice whose index is a multiple of `CHAIN` starts a chain, and its cascade input is 0 whatever the slice below it does.
- R6: For any other slice, the cascade input equals the OR sum of the slice below when that slice's forward bit (bit 5*TW+2) is set, and 0 otherwise. The cascade input is ORed into the slice's own sum.
- R7: Bits [5*TW+1:5*TW] pick the XOR second operand: 00 gives 0 (output = sum), 01 gives 1 (output = inverted sum), and 1x gives term 4 (output = sum XOR term 4), whether or not term 4 is enabled into the OR.
- R8: `fold_out[s]` is the inverse of the AND of the chosen term's global-input literals only. The term is chosen by bits [5*TW+5:5*TW+3], and values above 4 choose term 4.
- R9: Regional source k of a term in slice s is `fold_out[(s/REGION)*REGION + k]`. Slices in other regions never see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears all configuration |
| cfg_we | input | 1 | Write strobe for one slice configuration |
| cfg_addr | input | AW | Slice index to write |
| cfg_data | input | CW | Full configuration word for the addressed slice |
| glb | input | N_GLB | Global input bus seen by every term |
| sum_out | output | N_SLICE | XOR-stage output of each slice |
| fold_out | output | N_SLICE | Inverted foldback term of each slice, grouped by region |

## Verification
On every cycle the assertions check four things. Outputs hold still when neither a write nor an input change has occurred. A chain-head slice with no enabled term and a zero XOR operand stays low. A live cascade input forces the sum high. A foldback line is low whenever its chosen term's global part is true. Only the bench's scenarios can show the full function values: literal polarity and contradiction, ripple across a chain and its cut at the chain boundary, each XOR mode, the routing of foldback lines within one region and not others, and writes to an out-of-range address being dropped. These are swept over every global input pattern under directed and pseudo-random configurations.

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int N_SLICE = 16,
  parameter int N_GLB   = 8,
  parameter int REGION  = 16,
  parameter int CHAIN   = 8,
  parameter int AW      = (N_SLICE > 1) ? $clog2(N_SLICE) : 1,
  parameter int NSRC    = N_GLB + REGION,
  parameter int TW      = 1 + 2 * NSRC,
  parameter int CW      = 5 * TW + 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [CW-1:0]      cfg_data,
  input  logic [N_GLB-1:0]   glb,
  output logic [N_SLICE-1:0] sum_out,
  output logic [N_SLICE-1:0] fold_out
);
  localparam int NT = 5;
  localparam int B  = NT * TW;

  logic [CW-1:0] cfg_q [N_SLICE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLICE; i++) cfg_q[i] <= '0;
    end else if (cfg_we && (32'(cfg_addr) < N_SLICE)) begin
      cfg_q[cfg_addr] <= cfg_data;
    end
  end

  for (genvar s = 0; s < N_SLICE; s++) begin : g_sl
    localparam int RB = (s / REGION) * REGION;
    logic [CW-1:0]     c;
    logic [NT-1:0]     gand, pand, en;
    logic [REGION-1:0] rfb;
    logic [1:0]        mode;
    logic [2:0]        fsel;
    logic              fwd, cin, sum, xb;

    assign c    = cfg_q[s];
    assign rfb  = fold_out[RB +: REGION];
    assign mode = c[B+1:B];
    assign fwd  = c[B+2];
    assign fsel = c[B+5:B+3];

    for (genvar t = 0; t < NT; t++) begin : g_t
      logic [N_GLB-1:0]  gok;
      logic [REGION-1:0] rok;
      for (genvar k = 0; k < N_GLB; k++) begin : g_k
        assign gok[k] = (!c[t*TW+1+2*k] | glb[k]) & (!c[t*TW+2+2*k] | !glb[k]);
      end
      for (genvar k = 0; k < REGION; k++) begin : g_r
        assign rok[k] = (!c[t*TW+1+2*(N_GLB+k)] | rfb[k]) &
                        (!c[t*TW+2+2*(N_GLB+k)] | !rfb[k]);
      end
      assign gand[t] = &gok;
      assign pand[t] = gand[t] & (&rok);
      assign en[t]   = c[t*TW];
    end

    if (s % CHAIN == 0) begin : g_head
      assign cin = 1'b0;
      // R5
      head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && (en & pand) == '0) |-> !sum_out[s]);
    end else begin : g_link
      assign cin = g_sl[s-1].fwd & g_sl[s-1].sum;
    end

    assign sum         = (|(en & pand)) | cin;
    assign xb          = mode[1] ? pand[4] : mode[0];
    assign sum_out[s]  = sum ^ xb;
    assign fold_out[s] = (fsel > 3'd4) ? ~gand[4] : ~gand[fsel];

    // R6
    casc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cin && mode == 2'b00) |-> sum_out[s]);

    // R8
    fold_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel <= 3'd4 && gand[fsel]) |-> !fold_out[s]);
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_we) && $stable(glb)) |-> ($stable(sum_out) && $stable(fold_out)));
endmodule

// File: tb/tb_pterm_array.sv
module tb_pterm_array;
  localparam int NS = 6, NG = 4, RG = 3, CH = 3;
  localparam int AW = 3;
  localparam int TW = 1 + 2 * (NG + RG);
  localparam int CW = 5 * TW + 6;
  localparam int B  = 5 * TW;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [NG-1:0] glb = '0;
  logic [NS-1:0] sum_out, fold_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [CW-1:0] cf [NS];

  pterm_array #(.N_SLICE(NS), .N_GLB(NG), .REGION(RG), .CHAIN(CH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .glb(glb), .sum_out(sum_out), .fold_out(fold_out));

  always #2.5 clk = ~clk;

  function automatic int sb(int t, int k, int comp);
    return t * TW + 1 + 2 * k + comp;
  endfunction

  function automatic logic lit(logic [CW-1:0] c, int t, int k, logic v);
    return (!c[sb(t, k, 0)] || v) && (!c[sb(t, k, 1)] || !v);
  endfunction

  function automatic void model(input logic [NG-1:0] x,
                                output logic [NS-1:0] so, output logic [NS-1:0] fo);
    logic [4:0] ga [NS];
    logic [NS-1:0] sm;
    for (int s = 0; s < NS; s++) begin
      for (int t = 0; t < 5; t++) begin
        ga[s][t] = 1'b1;
        for (int k = 0; k < NG; k++) ga[s][t] &= lit(cf[s], t, k, x[k]);
      end
      fo[s] = ~ga[s][(cf[s][B+5:B+3] > 4) ? 4 : int'(cf[s][B+5:B+3])];
    end
    for (int s = 0; s < NS; s++) begin
      logic [4:0] pa;
      logic cin, xb;
      for (int t = 0; t < 5; t++) begin
        pa[t] = ga[s][t];
        for (int k = 0; k < RG; k++) pa[t] &= lit(cf[s], t, NG + k, fo[(s / RG) * RG + k]);
      end
      cin = 1'b0;
      if (s % CH != 0) cin = cf[s-1][B+2] & sm[s-1];
      sm[s] = cin;
      for (int t = 0; t < 5; t++) sm[s] |= cf[s][t*TW] & pa[t];
      xb = cf[s][B+1] ? pa[4] : cf[s][B];
      so[s] = sm[s] ^ xb;
    end
  endfunction

  task automatic chk(string r, logic [NS-1:0] act, logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_data = d;
    @(posedge clk);
    if (a < NS) cf[a] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sweep_model(string r);
    for (int v = 0; v < 16; v++) begin
      logic [NS-1:0] es, ef;
      glb = NG'(v);
      #0.5;
      model(glb, es, ef);
      chk({r, " sum"}, sum_out, es);
      chk({r, " fold"}, fold_out, ef);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [CW-1:0] w;
    for (int s = 0; s < NS; s++) cf[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5;
      chk("R1 reset sum", sum_out, '0);
      chk("R1 reset fold", fold_out, '0);
    end

    // R3/R4: literal polarity, empty term, contradiction, disabled term
    w = '0; w[0] = 1; w[sb(0, 2, 0)] = 1;
    wr(0, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R3 true literal", NS'(sum_out[0]), NS'(glb[2]));
    end
    w = '0; w[0] = 1; w[sb(0, 2, 1)] = 1;
    wr(0, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R3 complement literal", NS'(sum_out[0]), NS'(!glb[2]));
    end
    w = '0; w[0] = 1; w[sb(0, 1, 0)] = 1; w[sb(0, 1, 1)] = 1;
    wr(0, w);
    glb = 4'b0010; #0.5; chk("R3 contradiction", NS'(sum_out[0]), '0);
    w = '0; w[TW] = 1;
    wr(0, w);
    glb = 4'b0101; #0.5; chk("R3 empty term", NS'(sum_out[0]), NS'(1));
    w = '0; w[sb(0, 0, 0)] = 1;
    wr(0, w);
    glb = 4'b1111; #0.5; chk("R4 disabled term", NS'(sum_out[0]), '0);

    // R2: out-of-range address write is dropped
    w = '0; w[0] = 1; w[sb(0, 3, 0)] = 1;
    wr(0, w);
    wr(6, '1);
    wr(7, '1);
    sweep_model("R2 ignored address");

    // R5/R6: chain ripple and chain boundary
    for (int s = 0; s < 4; s++) begin
      w = '0; w[B+2] = 1;
      if (s < 3) begin w[0] = 1; w[sb(0, s, 0)] = 1; end
      wr(s, w);
    end
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5;
      chk("R6 chain ripple", NS'(sum_out[2]), NS'(glb[0] | glb[1] | glb[2]));
      chk("R5 chain head", NS'(sum_out[3]), '0);
    end
    w = cf[1]; w[B+2] = 0;
    wr(1, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R6 forward cleared", NS'(sum_out[2]), NS'(glb[2]));
    end

    // R7: XOR modes
    w = '0; w[0] = 1; w[sb(0, 0, 0)] = 1; w[sb(4, 1, 0)] = 1; w[B] = 1;
    wr(0, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R7 invert", NS'(sum_out[0]), NS'(!glb[0]));
    end
    w[B] = 0; w[B+1] = 1;
    wr(0, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R7 term xor", NS'(sum_out[0]), NS'(glb[0] ^ glb[1]));
    end

    // R8/R9: foldback and region routing
    for (int s = 0; s < NS; s++) wr(s, '0);
    w = '0; w[B+4] = 1; w[sb(2, 3, 1)] = 1;
    wr(0, w);
    w = '0; w[0] = 1; w[sb(0, NG + 0, 0)] = 1;
    wr(1, w);
    wr(3, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5;
      chk("R8 foldback", NS'(fold_out[0]), NS'(glb[3]));
      chk("R9 same region", NS'(sum_out[1]), NS'(glb[3]));
      chk("R9 other region", NS'(sum_out[3]), '0);
    end
    w = '0; w[B+5:B+3] = 3'd7; w[sb(4, 0, 0)] = 1;
    wr(2, w);
    for (int v = 0; v < 16; v++) begin
      glb = NG'(v); #0.5; chk("R8 select clamp", NS'(fold_out[2]), NS'(!glb[0]));
    end

    // R3..R9: pseudo-random sparse configurations against the model
    for (int round = 0; round < 30; round++) begin
      for (int s = 0; s < NS; s++) begin
        w = '0;
        for (int i = 0; i < CW; i++) begin
          w[i] = (($urandom % 5) == 0);
        end
        for (int t = 0; t < 5; t++) w[t*TW] = $urandom % 2;
        w[B+2] = $urandom % 2;
        wr(s, w);
      end
      sweep_model("R6 random");
    end

    finish_up();
  end
endmodule